// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits between a simple local request port and a single-lane serial NOR flash that uses 24-bit addresses. One request names an operation, a start address and a byte count. The block then builds the full serial exchange. It generates the clock, the active-low select and the outgoing data line, and it samples the incoming data line.

Program and erase requests always run the same sequence. First the block sends the write-arm command in a frame of its own. It then sends the operation. Finally it opens one status frame and reads status bytes in it until the device reports idle. Read data flows out as one-cycle byte strobes. Program data is pulled in over a valid/ready byte stream.

A request that is malformed never reaches the wire. This covers a misaligned erase address, a program that is empty, longer than one page or crossing a page boundary, a zero-length read, and an unknown operation code. Such a request is answered with a one-cycle error pulse.

The controller is a single state machine with these states:

- `S_IDLE`: accept a request.
- `S_PRE`: send the arming or reset-enable frame.
- `S_GAP`: hold select high between frames.
- `S_CMD`: send the opcode.
- `S_ADDR`: send three address bytes.
- `S_DUMMY`: send eight dummy clocks.
- `S_WDATA`: send write data.
- `S_RDATA`: receive read data.
- `S_POLL_CMD`: send the status opcode.
- `S_POLL_RD`: read status bytes.
- `S_FINISH`: pulse done or error.

The transitions are:

- `S_IDLE` goes to `S_FINISH` on a rejected request. Otherwise it goes to `S_PRE` for program, erase and reset, and to `S_CMD` for the rest.
- `S_PRE` goes to `S_GAP`, and `S_GAP` then goes to `S_CMD`.
- `S_CMD` goes to one of `S_ADDR`, `S_RDATA` (identification), `S_GAP` (chip erase) or `S_FINISH` (reset).
- `S_ADDR` goes to one of `S_DUMMY`, `S_RDATA`, `S_WDATA` or `S_GAP` (block erases).
- `S_DUMMY` goes to `S_RDATA`.
- `S_WDATA` goes to `S_GAP` after the last byte.
- After a poll-bound gap, `S_GAP` goes to `S_POLL_CMD`, which then goes to `S_POLL_RD`.
- `S_POLL_RD` goes to `S_FINISH` when the device reads idle or the poll budget is spent.
- `S_RDATA` goes to `S_FINISH` after the last byte, and `S_FINISH` returns to `S_IDLE`.

Top module: `flash_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `done`, `err`, `rd_valid` and `wr_ready` are 0.
- R2: The bus runs in clock mode 0. `spi_sck` idles low. `spi_mosi` changes only while `spi_sck` is low and is sampled by the flash on the rising edge. `spi_miso` is captured at the end of the high phase. Every byte goes most significant bit first.
- R3: Request code 0 (read) sends 03h and three address bytes, high byte first. It then returns `req_len` bytes on `rd_data`/`rd_valid` with no dummy clocks.
- R4: Request code 1 (fast read) sends 0Bh, the address and one byte of dummy clocks (8 clocks). It then returns `req_len` bytes.
- R5: Request codes 2 to 6 first send 06h alone in its own frame. `spi_cs_n` stays high for at least 2 clock cycles (one serial clock period) between any two frames.
- R6: Request code 2 (page program) sends 02h and the address. It then sends `req_len` bytes taken from `wr_data` over the `wr_valid`/`wr_ready` handshake. A full 256-byte page starting at a page boundary is accepted.
- R7: Request codes 3, 4 and 5 send 20h, 52h and D8h followed by the address. Code 6 sends C7h with no address.
- R8: After a program or erase, one frame sends 05h and then reads status bytes until bit 0 reads 0. `done` pulses only after that frame closes.
- R9: If `poll_limit` status bytes in a row read busy, the frame closes and `err` pulses instead of `done`.
- R10: Erase addresses must be aligned to their size: 4 KB for code 3, 32 KB for code 4 and 64 KB for code 5. Otherwise `err` pulses and no frame is opened.
- R11: A program with `req_len` of 0, above 256, or running past the end of its 256-byte page raises `err` with no frame. So does a read with `req_len` of 0.
- R12: Request code 7 sends 9Fh and returns exactly three identification bytes, whatever `req_len` is.
- R13: Request code 8 sends 66h in one frame, then 99h in a second frame, then pulses `done` without polling.
- R14: `req_ready` is high only in the idle state. `done` and `err` are single-cycle pulses that never occur together, and the block is ready in the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; the serial clock runs at half this rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 4 | Request code 0..8 (see requirements) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 9 | Byte count for read, fast read and program |
| poll_limit | input | 16 | Maximum busy status reads before timeout |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Program data byte taken this cycle when valid |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | Request completed normally |
| err | output | 1 | Request rejected or poll timeout |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The properties assume that `req_valid` is raised only while `req_ready` is high. They also assume that `spi_miso` is driven to a known level whenever a byte is being clocked, since a status byte with an unknown bit 0 would stall the poll decision. The bench meets both conditions. It waits for `req_ready` before each request and holds the request for exactly one cycle. Its flash model sets the data-out line to 0 when a frame opens and updates it only on falling serial clock edges. Program data is offered continuously, so the write stream never stalls for lack of data.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        REQ_READ      = 4'd0,
        REQ_FAST      = 4'd1,
        REQ_PROG      = 4'd2,
        REQ_ERASE_4K  = 4'd3,
        REQ_ERASE_32K = 4'd4,
        REQ_ERASE_64K = 4'd5,
        REQ_ERASE_ALL = 4'd6,
        REQ_READ_ID   = 4'd7,
        REQ_RESET     = 4'd8
    } req_op_e;

    localparam logic [7:0] OPC_READ     = 8'h03;
    localparam logic [7:0] OPC_FAST     = 8'h0B;
    localparam logic [7:0] OPC_WREN     = 8'h06;
    localparam logic [7:0] OPC_PROG     = 8'h02;
    localparam logic [7:0] OPC_SE4K     = 8'h20;
    localparam logic [7:0] OPC_BE32     = 8'h52;
    localparam logic [7:0] OPC_BE64     = 8'hD8;
    localparam logic [7:0] OPC_CHIP     = 8'hC7;
    localparam logic [7:0] OPC_STATUS   = 8'h05;
    localparam logic [7:0] OPC_ID       = 8'h9F;
    localparam logic [7:0] OPC_RST_EN   = 8'h66;
    localparam logic [7:0] OPC_RST_GO   = 8'h99;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] pre_op;
        logic       has_pre;
        logic       has_addr;
        logic       has_dummy;
        logic       wr_data;
        logic       rd_data;
        logic       poll;
        logic       bad;
    } cmd_info_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_GAP,
        S_CMD,
        S_ADDR,
        S_DUMMY,
        S_WDATA,
        S_RDATA,
        S_POLL_CMD,
        S_POLL_RD,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 9,
    parameter int PAGE_AW = 8,
    parameter int SEC_AW  = 12,
    parameter int B32_AW  = 15,
    parameter int B64_AW  = 16
) (
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output cmd_info_t         info,
    output logic [LEN_W-1:0]  xfer_len
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int SUM_W      = LEN_W + 1;
    localparam int ID_BYTES   = 3;

    logic [SUM_W-1:0] page_end;
    logic             prog_bad;
    logic             len_zero;

    assign len_zero = (len == '0);
    assign page_end = SUM_W'(addr[PAGE_AW-1:0]) + SUM_W'(len);
    assign prog_bad = len_zero || (page_end > SUM_W'(PAGE_BYTES));

    always_comb begin
        info          = '0;
        info.pre_op   = OPC_WREN;
        xfer_len      = len;
        unique case (op)
            REQ_READ: begin
                info.opcode   = OPC_READ;
                info.has_addr = 1'b1;
                info.rd_data  = 1'b1;
                info.bad      = len_zero;
            end
            REQ_FAST: begin
                info.opcode    = OPC_FAST;
                info.has_addr  = 1'b1;
                info.has_dummy = 1'b1;
                info.rd_data   = 1'b1;
                info.bad       = len_zero;
            end
            REQ_PROG: begin
                info.opcode   = OPC_PROG;
                info.has_pre  = 1'b1;
                info.has_addr = 1'b1;
                info.wr_data  = 1'b1;
                info.poll     = 1'b1;
                info.bad      = prog_bad;
            end
            REQ_ERASE_4K: begin
                info.opcode   = OPC_SE4K;
                info.has_pre  = 1'b1;
                info.has_addr = 1'b1;
                info.poll     = 1'b1;
                info.bad      = (addr[SEC_AW-1:0] != '0);
            end
            REQ_ERASE_32K: begin
                info.opcode   = OPC_BE32;
                info.has_pre  = 1'b1;
                info.has_addr = 1'b1;
                info.poll     = 1'b1;
                info.bad      = (addr[B32_AW-1:0] != '0);
            end
            REQ_ERASE_64K: begin
                info.opcode   = OPC_BE64;
                info.has_pre  = 1'b1;
                info.has_addr = 1'b1;
                info.poll     = 1'b1;
                info.bad      = (addr[B64_AW-1:0] != '0);
            end
            REQ_ERASE_ALL: begin
                info.opcode  = OPC_CHIP;
                info.has_pre = 1'b1;
                info.poll    = 1'b1;
            end
            REQ_READ_ID: begin
                info.opcode  = OPC_ID;
                info.rd_data = 1'b1;
                xfer_len     = LEN_W'(ID_BYTES);
            end
            REQ_RESET: begin
                info.opcode  = OPC_RST_GO;
                info.pre_op  = OPC_RST_EN;
                info.has_pre = 1'b1;
            end
            default: begin
                info.bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/flash_seq_shift.sv
module flash_seq_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx,
    input  logic            miso,
    output logic            busy,
    output logic            done,
    output logic [BITS-1:0] rx,
    output logic            sck,
    output logic            mosi
);
    localparam int CNT_W = $clog2(BITS);

    logic             phase;
    logic [CNT_W-1:0] bit_cnt;
    logic [BITS-1:0]  sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            phase   <= 1'b0;
            bit_cnt <= '0;
            sr      <= '0;
            rx      <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    phase   <= 1'b0;
                    bit_cnt <= '0;
                    sr      <= tx;
                end
            end else if (!phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                rx    <= {rx[BITS-2:0], miso};
                sr    <= {sr[BITS-2:0], 1'b0};
                if (bit_cnt == CNT_W'(BITS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign sck  = busy & phase;
    assign mosi = sr[BITS-1];

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 9,
    parameter int POLL_W  = 16,
    parameter int GAP_CYC = 2,
    parameter int PAGE_AW = 8,
    parameter int SEC_AW  = 12,
    parameter int B32_AW  = 15,
    parameter int B64_AW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [POLL_W-1:0] poll_limit,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              err,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int GAP_W      = $clog2(GAP_CYC + 1);

    seq_state_e        state_q, state_d, gap_tgt;
    cmd_info_t         dec_info, info_r;
    logic [LEN_W-1:0]  dec_len, xfer_r, cnt;
    logic [ADDR_W-1:0] addr_r;
    logic [POLL_W-1:0] poll_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              fail_r;
    logic              poll_last;
    logic              last_byte;

    logic              sh_start, sh_busy, sh_done;
    logic [7:0]        sh_tx, sh_rx;

    flash_seq_decode #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .PAGE_AW(PAGE_AW),
        .SEC_AW (SEC_AW),
        .B32_AW (B32_AW),
        .B64_AW (B64_AW)
    ) u_decode (
        .op      (req_op),
        .addr    (req_addr),
        .len     (req_len),
        .info    (dec_info),
        .xfer_len(dec_len)
    );

    flash_seq_shift #(
        .BITS(8)
    ) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .start(sh_start),
        .tx   (sh_tx),
        .miso (spi_miso),
        .busy (sh_busy),
        .done (sh_done),
        .rx   (sh_rx),
        .sck  (spi_sck),
        .mosi (spi_mosi)
    );

    assign poll_last = ({1'b0, poll_cnt} + 1'b1) >= {1'b0, poll_limit};
    assign last_byte = (cnt == xfer_r - 1'b1);

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            gap_tgt  <= S_CMD;
            info_r   <= '0;
            addr_r   <= '0;
            xfer_r   <= '0;
            fail_r   <= 1'b0;
            cnt      <= '0;
            poll_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                info_r <= dec_info;
                addr_r <= req_addr;
                xfer_r <= dec_len;
                fail_r <= dec_info.bad;
            end
            if (state_q == S_POLL_RD && sh_done && sh_rx[0] && poll_last)
                fail_r <= 1'b1;
            if (state_d == S_GAP && state_q != S_GAP)
                gap_tgt <= (state_q == S_PRE) ? S_CMD : S_POLL_CMD;
            if (state_d != state_q)
                cnt <= '0;
            else if (sh_done)
                cnt <= cnt + 1'b1;
            if (state_q != S_POLL_RD)
                poll_cnt <= '0;
            else if (sh_done)
                poll_cnt <= poll_cnt + 1'b1;
            if (state_q != S_GAP)
                gap_cnt <= '0;
            else
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (dec_info.bad)          state_d = S_FINISH;
                    else if (dec_info.has_pre) state_d = S_PRE;
                    else                       state_d = S_CMD;
                end
            end
            S_PRE: begin
                if (sh_done) state_d = S_GAP;
            end
            S_GAP: begin
                if (gap_cnt == GAP_W'(GAP_CYC - 1)) state_d = gap_tgt;
            end
            S_CMD: begin
                if (sh_done) begin
                    if (info_r.has_addr)     state_d = S_ADDR;
                    else if (info_r.rd_data) state_d = S_RDATA;
                    else if (info_r.poll)    state_d = S_GAP;
                    else                     state_d = S_FINISH;
                end
            end
            S_ADDR: begin
                if (sh_done && cnt == LEN_W'(ADDR_BYTES - 1)) begin
                    if (info_r.has_dummy)    state_d = S_DUMMY;
                    else if (info_r.rd_data) state_d = S_RDATA;
                    else if (info_r.wr_data) state_d = S_WDATA;
                    else                     state_d = S_GAP;
                end
            end
            S_DUMMY: begin
                if (sh_done) state_d = S_RDATA;
            end
            S_WDATA: begin
                if (sh_done && last_byte) state_d = S_GAP;
            end
            S_RDATA: begin
                if (sh_done && last_byte) state_d = S_FINISH;
            end
            S_POLL_CMD: begin
                if (sh_done) state_d = S_POLL_RD;
            end
            S_POLL_RD: begin
                if (sh_done && (!sh_rx[0] || poll_last)) state_d = S_FINISH;
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        logic in_frame;
        logic shifter_free;
        in_frame     = 1'b0;
        shifter_free = !sh_busy && !sh_done;
        sh_tx        = 8'h00;
        wr_ready     = 1'b0;
        req_ready    = 1'b0;
        done         = 1'b0;
        err          = 1'b0;
        rd_valid     = 1'b0;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_PRE: begin
                in_frame = 1'b1;
                sh_tx    = info_r.pre_op;
            end
            S_CMD: begin
                in_frame = 1'b1;
                sh_tx    = info_r.opcode;
            end
            S_ADDR: begin
                in_frame = 1'b1;
                sh_tx    = 8'(addr_r >> (8 * (ADDR_BYTES - 1 - int'(cnt))));
            end
            S_DUMMY:    in_frame = 1'b1;
            S_WDATA: begin
                in_frame = 1'b1;
                sh_tx    = wr_data;
                wr_ready = shifter_free;
            end
            S_RDATA: begin
                in_frame = 1'b1;
                rd_valid = sh_done;
            end
            S_POLL_CMD: begin
                in_frame = 1'b1;
                sh_tx    = OPC_STATUS;
            end
            S_POLL_RD:  in_frame = 1'b1;
            S_FINISH: begin
                done = !fail_r;
                err  = fail_r;
            end
            default: ;
        endcase
        spi_cs_n = !in_frame;
        sh_start = in_frame && shifter_free &&
                   (state_q != S_WDATA || wr_valid);
    end

    assign rd_data = sh_rx;

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic wr_ready,
    input logic rd_valid,
    input logic done,
    input logic err,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R2

    AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi)); // R2

    AST_SCK_SINGLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |=> !spi_sck); // R2

    AST_RD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n); // R3

    AST_WR_TAKE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!spi_cs_n && !spi_sck)); // R6

    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> spi_cs_n); // R8

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R14

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> (!done && !err && req_ready)); // R14

    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n); // R14

endmodule

bind flash_seq flash_seq_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_ready(req_ready),
    .wr_ready(wr_ready),
    .rd_valid(rd_valid),
    .done    (done),
    .err     (err),
    .spi_sck (spi_sck),
    .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXF = 8;
    localparam int MAXB = 264;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [8:0]  req_len = '0;
    logic [15:0] poll_limit = 16'd50;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done, err;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_seq u_flash_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .poll_limit(poll_limit), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .err(err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Write stream source
    int wr_idx = 0;
    assign wr_data = 8'(8'hA0 + wr_idx);
    always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;

    // Read stream sink
    logic [7:0] rd_buf [0:MAXB-1];
    int rd_n = 0;
    always @(posedge clk) if (rd_valid) begin
        if (rd_n < MAXB) rd_buf[rd_n] <= rd_data;
        rd_n <= rd_n + 1;
    end

    // Flash model: frame capture and responses
    logic [7:0] fb [0:MAXF-1][0:MAXB-1];
    int  flen [0:MAXF-1];
    int  fcount = 0;
    int  bitc = 0;
    bit  in_fr = 0;
    logic [7:0] shin = '0;
    int  busy_polls = 0;
    int  hi_cnt = 0;
    int  min_gap = 1000;

    function automatic logic [7:0] resp(int k);
        logic [7:0] op, a;
        if (fcount >= MAXF || k < 1) return 8'h00;
        op = fb[fcount][0];
        a  = fb[fcount][3];
        case (op)
            8'h03: return (k >= 4) ? (8'(a + 8'(k - 4)) ^ 8'h5A) : 8'h00;
            8'h0B: return (k >= 5) ? (8'(a + 8'(k - 5)) ^ 8'h5A) : 8'h00;
            8'h9F: return (k == 1) ? 8'hC2 : (k == 2) ? 8'h20 : (k == 3) ? 8'h18 : 8'h00;
            8'h05: return (k <= busy_polls) ? 8'h03 : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge spi_cs_n) begin
        bitc = 0;
        in_fr = 1;
        spi_miso = 1'b0;
    end

    always @(posedge spi_cs_n) begin
        if (in_fr) begin
            if (fcount < MAXF) flen[fcount] = bitc / 8;
            fcount = fcount + 1;
            in_fr = 0;
        end
    end

    always @(posedge spi_sck) begin
        shin = {shin[6:0], spi_mosi};
        bitc = bitc + 1;
        if (bitc % 8 == 0 && fcount < MAXF && bitc / 8 <= MAXB)
            fb[fcount][bitc/8 - 1] = shin;
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            logic [7:0] r;
            r = resp(bitc / 8);
            spi_miso = r[7 - (bitc % 8)];
        end
    end

    always @(posedge clk) begin
        if (spi_cs_n) hi_cnt <= hi_cnt + 1;
        else begin
            if (hi_cnt != 0 && fcount > 0 && hi_cnt < min_gap) min_gap <= hi_cnt;
            hi_cnt <= 0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [23:0] a,
                         input logic [8:0] len, output bit got_done, output bit got_err);
        got_done = 0;
        got_err = 0;
        fcount = 0;
        rd_n = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_addr = a; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R14 ready low after accept", int'(req_ready), 0);
        for (int i = 0; i < 20000; i++) begin
            if (done) got_done = 1;
            if (err)  got_err = 1;
            if (got_done || got_err) break;
            @(negedge clk);
        end
        @(negedge clk);
        check("R14 single-cycle pulse", int'(done | err), 0);
        check("R14 ready after finish", int'(req_ready), 1);
    endtask

    task automatic t_reset();
        check("R1 cs_n", int'(spi_cs_n), 1);
        check("R1 sck", int'(spi_sck), 0);
        check("R1 ready", int'(req_ready), 1);
        check("R1 done/err", int'({done, err, rd_valid, wr_ready}), 0);
    endtask

    task automatic t_read();
        bit d, e;
        issue(4'd0, 24'h123456, 9'd4, d, e);
        check("R3 done", int'(d), 1);
        check("R3 frames", fcount, 1);
        check("R3 frame len", flen[0], 8);
        check("R3 opcode", int'(fb[0][0]), 8'h03);
        check("R3 addr msb first", int'({fb[0][1], fb[0][2], fb[0][3]}), 24'h123456);
        check("R3 count", rd_n, 4);
        for (int i = 0; i < 4; i++)
            check("R3 data", int'(rd_buf[i]), int'(8'(8'h56 + i) ^ 8'h5A));
    endtask

    task automatic t_fast();
        bit d, e;
        issue(4'd1, 24'h0000F0, 9'd2, d, e);
        check("R4 done", int'(d), 1);
        check("R4 opcode", int'(fb[0][0]), 8'h0B);
        check("R4 frame len with dummy", flen[0], 7);
        for (int i = 0; i < 2; i++)
            check("R4 data", int'(rd_buf[i]), int'(8'(8'hF0 + i) ^ 8'h5A));
    endtask

    task automatic t_prog(input logic [23:0] a, input int n);
        bit d, e;
        int base;
        busy_polls = 2;
        base = wr_idx;
        issue(4'd2, a, 9'(n), d, e);
        check("R8 done", int'(d), 1);
        check("R5 frames", fcount, 3);
        check("R5 wren alone", int'(fb[0][0]), 8'h06);
        check("R5 wren len", flen[0], 1);
        check("R6 opcode", int'(fb[1][0]), 8'h02);
        check("R6 addr", int'({fb[1][1], fb[1][2], fb[1][3]}), int'(a));
        check("R6 frame len", flen[1], 4 + n);
        check("R6 first byte", int'(fb[1][4]), int'(8'(8'hA0 + base)));
        check("R6 last byte", int'(fb[1][3 + n]), int'(8'(8'hA0 + base + n - 1)));
        check("R8 poll opcode", int'(fb[2][0]), 8'h05);
        check("R8 poll single frame", flen[2], 4);
    endtask

    task automatic t_erase(input logic [3:0] op, input logic [23:0] a,
                           input logic [7:0] opc, input int blen);
        bit d, e;
        busy_polls = 1;
        issue(op, a, 9'd0, d, e);
        check("R7 done", int'(d), 1);
        check("R7 frames", fcount, 3);
        check("R5 wren first", int'(fb[0][0]), 8'h06);
        check("R7 opcode", int'(fb[1][0]), int'(opc));
        check("R7 frame len", flen[1], blen);
        check("R8 poll len", flen[2], 3);
    endtask

    task automatic t_timeout();
        bit d, e;
        busy_polls = 100;
        poll_limit = 16'd4;
        issue(4'd3, 24'h005000, 9'd0, d, e);
        check("R9 err", int'(e), 1);
        check("R9 no done", int'(d), 0);
        check("R9 poll bytes", flen[2], 5);
        poll_limit = 16'd50;
        busy_polls = 0;
    endtask

    task automatic t_reject(input string tag, input logic [3:0] op,
                            input logic [23:0] a, input logic [8:0] len);
        bit d, e;
        issue(op, a, len, d, e);
        check({tag, " err"}, int'(e), 1);
        check({tag, " no done"}, int'(d), 0);
        check({tag, " no frame"}, fcount, 0);
    endtask

    task automatic t_id();
        bit d, e;
        issue(4'd7, 24'h0, 9'd9, d, e);
        check("R12 opcode", int'(fb[0][0]), 8'h9F);
        check("R12 count", rd_n, 3);
        check("R12 id", int'({rd_buf[0], rd_buf[1], rd_buf[2]}), 24'hC22018);
    endtask

    task automatic t_swreset();
        bit d, e;
        issue(4'd8, 24'h0, 9'd0, d, e);
        check("R13 done", int'(d), 1);
        check("R13 frames", fcount, 2);
        check("R13 enable", int'(fb[0][0]), 8'h66);
        check("R13 go", int'(fb[1][0]), 8'h99);
        check("R13 lens", flen[0] + flen[1], 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr_valid = 1'b1;
        t_read();
        t_fast();
        t_prog(24'h001000, 4);
        t_prog(24'h000200, 256);
        t_erase(4'd3, 24'h003000, 8'hD8 ^ 8'hF8, 4);
        t_erase(4'd4, 24'h008000, 8'h52, 4);
        t_erase(4'd5, 24'h010000, 8'hD8, 4);
        t_erase(4'd6, 24'h000000, 8'hC7, 1);
        t_timeout();
        t_reject("R10 sector", 4'd3, 24'h003100, 9'd0);
        t_reject("R10 block32", 4'd4, 24'h004000, 9'd0);
        t_reject("R10 block64", 4'd5, 24'h018000, 9'd0);
        t_reject("R11 long", 4'd2, 24'h000000, 9'd300);
        t_reject("R11 cross", 4'd2, 24'h0000F0, 9'd32);
        t_reject("R11 empty", 4'd2, 24'h000100, 9'd0);
        t_reject("R11 empty read", 4'd0, 24'h000100, 9'd0);
        t_id();
        t_swreset();
        check("R5 min cs high gap >= 2", int'(min_gap >= 2), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule